// File: doc/BRIEF.md
# ALU Status Flag Register

This block holds the arithmetic condition flags of an 8-bit processor: negative, signed overflow, zero, nibble carry and carry. On each executed instruction it takes the ALU operands, the ALU result, an operation class and a per-flag update mask from decode. From these it works out fresh flag values and merges them into the stored flags. Flags outside the mask keep their old value.

The register can also be the destination of an instruction. When that instruction affects no flag (mask all zero), the write data lands on the five flag bits directly. When the instruction does affect flags, the flag logic owns all five bits. The write data is then discarded: masked bits take the computed value and the other flag bits keep their value. Bits 7 to 5 do not exist and always read as zero.

Subtraction is done as the addition of the two's complement of the second operand. As a result, carry and nibble carry read 1 when no borrow occurred. A new value is visible on the read port one clock after the executing cycle.

Top module: `alu_flag_reg`

## Requirements
- R1: rd_data[7:5] always reads 0, whatever is written. The flags sit at rd_data[4]=N, [3]=OV, [2]=Z, [1]=DC and [0]=C. flag_mask uses the same bit positions.
- R2: While rst_n is low, the five flag bits are 0.
- R3: When exec is high and the N or Z mask bit is set, N takes result[7] and Z takes (result == 0) in the next cycle. Operation class 5 (clear) is the exception.
- R4: Class 0 (add, result = op_a + op_b): C is the carry out of bit 7, DC is the carry out of bit 3, and OV is 1 when both operands have the same sign and the result sign differs from it.
- R5: Class 1 (subtract, result = op_a - op_b): C is 1 when op_a >= op_b (unsigned) and DC is 1 when op_a[3:0] >= op_b[3:0]. OV is 1 when the operand signs differ and the result sign differs from op_a.
- R6: Class 2 (rotate left through carry) loads C with op_a[7] and DC with op_a[3]. Class 3 (rotate right) loads C with op_a[0] and DC with op_a[4].
- R7: Class 4 (logic) and classes 6 and 7 give OV=0 and leave C and DC unchanged. Class 5 (clear) gives N=0 and Z=1, gives OV=0, and leaves C and DC unchanged.
- R8: On an executed instruction with a nonzero mask, each flag whose mask bit is 0 keeps its value.
- R9: When exec and dst_stat are high and flag_mask is nonzero, wr_data is ignored. Flags follow R3 to R8.
- R10: When exec and dst_stat are high and flag_mask is zero, flags take wr_data[4:0] in the next cycle.
- R11: When exec is low, or exec is high with dst_stat low and a zero mask, all flags keep their value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| exec | input | 1 | Instruction executes this cycle |
| op_class | input | 3 | Operation class (0 add, 1 sub, 2 rotate left, 3 rotate right, 4 logic, 5 clear) |
| op_a | input | 8 | First ALU operand / rotate source |
| op_b | input | 8 | Second ALU operand |
| result | input | 8 | ALU result |
| flag_mask | input | 5 | Flags affected by the instruction |
| dst_stat | input | 1 | Instruction writes the status register |
| wr_data | input | 8 | Data for a direct write |
| rd_data | output | 8 | Status register readback |

## Verification
The checks on N and Z rely on decode supplying a result that matches the operation class. In particular, they rely on a clear presenting a zero result. The stimulus therefore always computes result from op_a, op_b, the class and the current carry, and never drives an arbitrary value for it. The hold and direct-write checks assume that the mask is the only thing marking an instruction as flag-affecting. The bench therefore drives random masks, including all-zero, independently of dst_stat, so that both the write path and the suppression path are covered.

// File: rtl/alu_flag_reg.sv
module alu_flag_reg (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       exec,
  input  logic [2:0] op_class,
  input  logic [7:0] op_a,
  input  logic [7:0] op_b,
  input  logic [7:0] result,
  input  logic [4:0] flag_mask,
  input  logic       dst_stat,
  input  logic [7:0] wr_data,
  output logic [7:0] rd_data
);
  localparam logic [2:0] CL_ADD = 3'd0;
  localparam logic [2:0] CL_SUB = 3'd1;
  localparam logic [2:0] CL_RLC = 3'd2;
  localparam logic [2:0] CL_RRC = 3'd3;
  localparam logic [2:0] CL_CLR = 3'd5;

  localparam int BN = 4, BV = 3, BZ = 2, BD = 1, BC = 0;

  logic [4:0] flags_q, flag_new, flags_d;

  wire [8:0] add_full = {1'b0, op_a} + {1'b0, op_b};
  wire [4:0] add_low  = {1'b0, op_a[3:0]} + {1'b0, op_b[3:0]};
  wire [8:0] sub_full = {1'b0, op_a} + {1'b0, ~op_b} + 9'd1;
  wire [4:0] sub_low  = {1'b0, op_a[3:0]} + {1'b0, ~op_b[3:0]} + 5'd1;

  wire ov_add = (op_a[7] == op_b[7]) && (result[7] != op_a[7]);
  wire ov_sub = (op_a[7] != op_b[7]) && (result[7] != op_a[7]);
  wire affects = |flag_mask;

  always_comb begin
    flag_new     = flags_q;
    flag_new[BN] = result[7];
    flag_new[BZ] = ~|result;
    flag_new[BV] = 1'b0;
    case (op_class)
      CL_ADD: begin
        flag_new[BV] = ov_add;
        flag_new[BD] = add_low[4];
        flag_new[BC] = add_full[8];
      end
      CL_SUB: begin
        flag_new[BV] = ov_sub;
        flag_new[BD] = sub_low[4];
        flag_new[BC] = sub_full[8];
      end
      CL_RLC: begin
        flag_new[BD] = op_a[3];
        flag_new[BC] = op_a[7];
      end
      CL_RRC: begin
        flag_new[BD] = op_a[4];
        flag_new[BC] = op_a[0];
      end
      CL_CLR: begin
        flag_new[BN] = 1'b0;
        flag_new[BZ] = 1'b1;
      end
      default: ;
    endcase
  end

  always_comb begin
    flags_d = flags_q;
    if (exec) begin
      if (dst_stat && !affects)
        flags_d = wr_data[4:0];
      else
        flags_d = (flag_new & flag_mask) | (flags_q & ~flag_mask);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) flags_q <= 5'b0;
    else        flags_q <= flags_d;
  end

  assign rd_data = {3'b000, flags_q};
endmodule

module alu_flag_reg_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       exec,
  input logic [2:0] op_class,
  input logic [7:0] op_a,
  input logic [7:0] op_b,
  input logic [7:0] result,
  input logic [4:0] flag_mask,
  input logic       dst_stat,
  input logic [7:0] wr_data,
  input logic [7:0] rd_data
);
  always_comb begin
    if (!rst_n) AST_RESET_CLEAR: assert (rd_data == 8'h00); // R2
  end

  AST_UPPER_ZERO: assert property (@(posedge clk) disable iff (!rst_n) rd_data[7:5] == 3'b000); // R1

  AST_N_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
    exec && flag_mask[4] && op_class != 3'd5 |=> rd_data[4] == $past(result[7])); // R3

  AST_Z_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
    exec && flag_mask[2] |=> rd_data[2] == ($past(result) == 8'h00)); // R3

  AST_UNMASKED_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    exec && (|flag_mask) |=> ((rd_data[4:0] ^ $past(rd_data[4:0])) & ~$past(flag_mask)) == 5'b0); // R8

  AST_WRITE_BLOCKED: assert property (@(posedge clk) disable iff (!rst_n)
    exec && dst_stat && (|flag_mask) |=> ((rd_data[4:0] ^ $past(rd_data[4:0])) & ~$past(flag_mask)) == 5'b0); // R9

  AST_DIRECT_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    exec && dst_stat && flag_mask == 5'b0 |=> rd_data[4:0] == $past(wr_data[4:0])); // R10

  AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !exec || (!dst_stat && flag_mask == 5'b0) |=> $stable(rd_data)); // R11
endmodule

bind alu_flag_reg alu_flag_reg_chk chk_i (.*);

// File: tb/alu_flag_reg_tb.sv
`timescale 1ns/100ps
module alu_flag_reg_tb_top;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       exec = 1'b0;
  logic [2:0] op_class = 3'd0;
  logic [7:0] op_a = 8'h00, op_b = 8'h00, result = 8'h00, wr_data = 8'h00;
  logic [4:0] flag_mask = 5'b0;
  logic       dst_stat = 1'b0;
  logic [7:0] rd_data;

  int errors = 0;
  int checks = 0;
  bit done = 1'b0;
  logic [4:0] mdl = 5'b0;

  always #2.5 clk = ~clk;

  alu_flag_reg dut_i (
    .clk(clk), .rst_n(rst_n), .exec(exec), .op_class(op_class),
    .op_a(op_a), .op_b(op_b), .result(result), .flag_mask(flag_mask),
    .dst_stat(dst_stat), .wr_data(wr_data), .rd_data(rd_data)
  );

  function automatic int sgn(input int v);
    return (v > 127) ? v - 256 : v;
  endfunction

  function automatic logic [7:0] alu_out(input int cls, input int a, input int b, input logic cin);
    case (cls)
      0: return 8'((a + b) % 256);
      1: return 8'((a - b + 256) % 256);
      2: return 8'(((a * 2) + cin) % 256);
      3: return 8'((a / 2) + (cin ? 128 : 0));
      5: return 8'h00;
      default: return 8'(a ^ b);
    endcase
  endfunction

  function automatic logic [4:0] next_flags(input logic [4:0] cur, input bit ex, input int cls,
      input int a, input int b, input int r, input logic [4:0] m, input bit dst, input int wd);
    logic n, v, z, d, c;
    int s;
    if (!ex) return cur;
    if (dst && m == 5'b0) return 5'(wd % 32);
    n = (r >= 128);
    z = (r == 0);
    v = 1'b0;
    d = cur[1];
    c = cur[0];
    case (cls)
      0: begin
        s = sgn(a) + sgn(b);
        v = (s > 127) || (s < -128);
        d = ((a % 16) + (b % 16)) > 15;
        c = (a + b) > 255;
      end
      1: begin
        s = sgn(a) - sgn(b);
        v = (s > 127) || (s < -128);
        d = (a % 16) >= (b % 16);
        c = a >= b;
      end
      2: begin c = (a / 128) % 2 == 1; d = (a / 8) % 2 == 1; end
      3: begin c = a % 2 == 1; d = (a / 16) % 2 == 1; end
      5: begin n = 1'b0; z = 1'b1; end
      default: ;
    endcase
    return ({n, v, z, d, c} & m) | (cur & ~m);
  endfunction

  task automatic step(input bit ex, input int cls, input int a, input int b,
                      input logic [4:0] m, input bit dst, input int wd, input string tag);
    logic [7:0] r;
    r = alu_out(cls, a, b, mdl[0]);
    exec = ex; op_class = 3'(cls); op_a = 8'(a); op_b = 8'(b); result = r;
    flag_mask = m; dst_stat = dst; wr_data = 8'(wd);
    mdl = next_flags(mdl, ex, cls, a, b, int'(r), m, dst, wd);
    @(negedge clk);
    checks++;
    if (rd_data !== {3'b000, mdl}) begin
      errors++;
      $display("FAIL %s: rd_data=%h expected %h", tag, rd_data, {3'b000, mdl});
    end
  endtask

  initial begin
    #(5.0 * 150000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: run hung, actual=timeout expected=completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    checks++;
    if (rd_data !== 8'h00) begin
      errors++;
      $display("FAIL R2: rd_data=%h expected 00", rd_data);
    end
    rst_n = 1'b1;
    @(negedge clk);

    step(1, 4, 0, 0, 5'b0, 1, 8'hFF, "R10 write all ones, R1 upper zero");
    step(1, 4, 0, 0, 5'b0, 1, 8'hE0, "R1 upper bits ignored");
    step(1, 0, 8'h7F, 8'h01, 5'h1F, 0, 0, "R4 add signed overflow");
    step(1, 0, 8'hFF, 8'h01, 5'h1F, 0, 0, "R4 add carry zero");
    step(1, 0, 8'h0F, 8'h01, 5'h1F, 0, 0, "R4 add nibble carry");
    step(1, 0, 8'h80, 8'h80, 5'h1F, 0, 0, "R4 add negative overflow");
    step(1, 1, 8'h05, 8'h05, 5'h1F, 0, 0, "R5 sub equal no borrow");
    step(1, 1, 8'h03, 8'h05, 5'h1F, 0, 0, "R5 sub borrow");
    step(1, 1, 8'h10, 8'h01, 5'h1F, 0, 0, "R5 sub nibble borrow");
    step(1, 1, 8'h80, 8'h01, 5'h1F, 0, 0, "R5 sub overflow");
    step(1, 2, 8'h88, 0, 5'h17, 0, 0, "R6 rotate left");
    step(1, 3, 8'h11, 0, 5'h17, 0, 0, "R6 rotate right");
    step(1, 4, 8'hF0, 8'h0F, 5'h1F, 0, 0, "R7 logic keeps carries");
    step(1, 5, 8'h33, 0, 5'h04, 1, 8'h00, "R7 R9 clear to status");
    step(1, 0, 8'h01, 8'h02, 5'h04, 0, 0, "R3 zero only");
    step(1, 0, 8'h90, 8'h01, 5'h10, 0, 0, "R3 negative only");
    step(1, 1, 8'h00, 8'h01, 5'h01, 0, 0, "R8 carry only masked");
    step(1, 0, 8'hFF, 8'hFF, 5'h03, 1, 8'h1C, "R9 write suppressed");
    step(1, 0, 8'h01, 8'h01, 5'h1F, 1, 8'hFF, "R9 write suppressed all");
    step(0, 0, 8'hFF, 8'hFF, 5'h1F, 1, 8'h1F, "R11 exec low holds");
    step(1, 0, 8'hFF, 8'hFF, 5'h00, 0, 8'h1F, "R11 no mask no dest holds");
    step(1, 4, 0, 0, 5'b0, 1, 8'h15, "R10 pattern");

    for (int i = 0; i < 3000; i++) begin
      int cls;
      logic [4:0] m;
      cls = $urandom_range(0, 7);
      m = 5'($urandom_range(0, 31));
      if ($urandom_range(0, 3) == 0) m = 5'b0;
      step($urandom_range(0, 7) != 0, cls, $urandom_range(0, 255), $urandom_range(0, 255),
           m, $urandom_range(0, 1), $urandom_range(0, 255), "R3 R8 R9 R10 random");
    end

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule